// File: doc/BRIEF.md
# STN Panel Clock and AC Bias Generator

This block derives the pixel clock for a passive-matrix (STN) LCD panel from the system bus clock. The division ratio is the programmed 10-bit divider value plus two. In STN mode, the block raises the effective value to a floor that depends on the panel organisation and flags the request as illegal. With each panel clock period it issues a single-cycle enable pulse, aligned to the rising edge of the panel clock, so that downstream pixel logic can stay in the bus clock domain.

The block also drives the AC bias (polarity) line of the panel. It counts line-done strobes from the sync timing generator and inverts the bias line once every programmed number of lines. This keeps DC charge from building up in the liquid crystal. The bias line only matters for STN panels, so in TFT mode it is forced low and its line counter is cleared.

The block loads new divider and bias-period settings only at a panel clock period boundary. A change made partway through a period therefore never produces a clipped pixel clock.

Top module: `lcd_pclk_bias`

## Requirements
- R1: The panel clock period is (PCD + 2) bus clock cycles. PCD is the 10-bit value {div_hi_i, div_lo_i}, with div_hi_i as the upper five bits.
- R2: In STN mode the divider value in use is max(PCD, floor). The floor per panel_mode_i code is: 0 single colour → 1; 1 dual colour → 4; 2 single 4-bit mono → 2; 3 dual 4-bit mono → 6; 4 single 8-bit mono → 6; 5 dual 8-bit mono → 14; 6 and 7 → 14.
- R3: div_clamp_o is high, combinationally, exactly when stn_en_i is high and PCD is below the floor for the selected mode.
- R4: In TFT mode (stn_en_i low) no floor applies and div_clamp_o stays low. The ratio is PCD + 2, down to 2.
- R5: Within each period pclk_o is high for the first floor(ratio/2) bus cycles. pclk_en_o is high for exactly the one bus cycle in which the period starts.
- R6: A divider setting change made partway through a period does not alter that period. The change applies from the next period start.
- R7: In STN mode, bias_o inverts on every (bias_len_i + 1)-th line-done strobe. This allows 1 to 32 lines per phase.
- R8: In TFT mode, bias_o is low and line-done strobes have no effect. The line counter and the bias state are cleared, so STN operation resumes with bias low and a fresh count.
- R9: The bias period setting is loaded only at a panel clock period start. A strobe in that same cycle is judged against the previous setting.
- R10: While rst_ni is low, pclk_o, pclk_en_o and bias_o are low and both counters are zero. The first period starts on the first clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_done_i | input | 1 | One-cycle strobe at the end of each display line |
| div_lo_i | input | 5 | Lower five bits of the divider value PCD |
| div_hi_i | input | 5 | Upper five bits of the divider value PCD |
| bias_len_i | input | 5 | Lines per bias phase, minus one |
| panel_mode_i | input | 3 | Panel organisation code (see R2) |
| stn_en_i | input | 1 | 1 = STN panel, 0 = TFT panel |
| pclk_o | output | 1 | Panel pixel clock |
| pclk_en_o | output | 1 | One-cycle pulse at the start of each panel clock period |
| bias_o | output | 1 | AC bias / polarity line |
| div_clamp_o | output | 1 | PCD is below the floor for the selected STN mode |

## Verification
Two events can fall on the same bus clock edge: a panel clock period boundary that loads a new bias period, and a line-done strobe. The bench provokes this by running a divide-by-3 clock with a bias period of one line. It waits for the enable pulse, counts two cycles to reach the last cycle of the period, and then changes the bias setting and raises the strobe together. The bias line must still invert on that strobe, because the old setting applies. From then on, four strobes must be needed per inversion.

// File: rtl/lcd_pclk_pkg.sv
package lcd_pclk_pkg;

  localparam int unsigned PCD_W   = 10;
  localparam int unsigned FIELD_W = 5;
  localparam int unsigned MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_COL_SINGLE  = 3'd0,
    MODE_COL_DUAL    = 3'd1,
    MODE_MONO4_SINGLE = 3'd2,
    MODE_MONO4_DUAL  = 3'd3,
    MODE_MONO8_SINGLE = 3'd4,
    MODE_MONO8_DUAL  = 3'd5
  } panel_mode_e;

  // Minimum divider value per panel organisation; reserved codes take the strictest.
  function automatic logic [PCD_W-1:0] pcd_floor(input logic [MODE_W-1:0] mode);
    case (mode)
      MODE_COL_SINGLE:   pcd_floor = PCD_W'(1);
      MODE_COL_DUAL:     pcd_floor = PCD_W'(4);
      MODE_MONO4_SINGLE: pcd_floor = PCD_W'(2);
      MODE_MONO4_DUAL:   pcd_floor = PCD_W'(6);
      MODE_MONO8_SINGLE: pcd_floor = PCD_W'(6);
      default:           pcd_floor = PCD_W'(14);
    endcase
  endfunction

endpackage

// File: rtl/pcd_limit.sv
module pcd_limit
  import lcd_pclk_pkg::*;
#(
  parameter int unsigned PW = PCD_W,
  parameter int unsigned MW = MODE_W
) (
  input  logic [PW-1:0] pcd_i,
  input  logic [MW-1:0] mode_i,
  input  logic          stn_i,
  output logic [PW-1:0] pcd_o,
  output logic          clamp_o
);

  logic [PW-1:0] floor_v;

  always_comb begin
    floor_v = PW'(pcd_floor(MODE_W'(mode_i)));
    clamp_o = stn_i && (pcd_i < floor_v);
    pcd_o   = clamp_o ? floor_v : pcd_i;
  end

  always_comb begin
    AST_CLAMP_RESULT_ABOVE_FLOOR: assert (!stn_i || (pcd_o >= floor_v)); // R2
  end

endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ratio_i,
  output logic          pclk_o,
  output logic          pclk_en_o,
  output logic          bound_o
);

  logic [CW-1:0] cnt_q, term_q, half_q;
  logic [CW-1:0] cnt_nxt;
  logic          pclk_q, en_q;

  assign bound_o = (cnt_q == term_q);
  assign cnt_nxt = cnt_q + CW'(1);

  // term_q resets to 0 so the first edge after reset is a period start.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      term_q <= '0;
      half_q <= '0;
      pclk_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (bound_o) begin
      cnt_q  <= '0;
      term_q <= ratio_i - CW'(1);
      half_q <= ratio_i >> 1;
      pclk_q <= 1'b1;
      en_q   <= 1'b1;
    end else begin
      cnt_q  <= cnt_nxt;
      pclk_q <= cnt_nxt < half_q;
      en_q   <= 1'b0;
    end
  end

  assign pclk_o    = pclk_q;
  assign pclk_en_o = en_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_q); // R1
  AST_EN_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |=> !pclk_en_o); // R5
  AST_EN_WITH_HIGH_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_en_o |-> pclk_o); // R5
  AST_FALL_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pclk_o) |-> (cnt_q == half_q)); // R5

endmodule

// File: rtl/bias_toggle.sv
module bias_toggle #(
  parameter int unsigned LW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stn_i,
  input  logic          line_i,
  input  logic          load_i,
  input  logic [LW-1:0] len_i,
  output logic          bias_o
);

  logic [LW-1:0] lines_q, len_q;
  logic          bias_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
    end else if (load_i) begin
      len_q <= len_i;
    end
  end

  // >= guards against a shorter period loaded while the count is past it.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lines_q <= '0;
      bias_q  <= 1'b0;
    end else if (!stn_i) begin
      lines_q <= '0;
      bias_q  <= 1'b0;
    end else if (line_i) begin
      if (lines_q >= len_q) begin
        lines_q <= '0;
        bias_q  <= ~bias_q;
      end else begin
        lines_q <= lines_q + LW'(1);
      end
    end
  end

  assign bias_o = stn_i & bias_q;

  AST_BIAS_MOVES_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bias_q != $past(bias_q)) && $past(stn_i) |-> $past(line_i)); // R7
  AST_TFT_CLEARS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stn_i |=> (lines_q == '0) && !bias_q); // R8
  AST_LEN_ONLY_AT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> $stable(len_q)); // R9

endmodule

// File: rtl/lcd_pclk_bias.sv
module lcd_pclk_bias
  import lcd_pclk_pkg::*;
#(
  parameter int unsigned LO_W   = FIELD_W,
  parameter int unsigned HI_W   = FIELD_W,
  parameter int unsigned BIAS_W = 5,
  parameter int unsigned MD_W   = MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_done_i,
  input  logic [LO_W-1:0]   div_lo_i,
  input  logic [HI_W-1:0]   div_hi_i,
  input  logic [BIAS_W-1:0] bias_len_i,
  input  logic [MD_W-1:0]   panel_mode_i,
  input  logic              stn_en_i,
  output logic              pclk_o,
  output logic              pclk_en_o,
  output logic              bias_o,
  output logic              div_clamp_o
);

  localparam int unsigned PW = LO_W + HI_W;
  localparam int unsigned CW = PW + 1;

  logic [PW-1:0] pcd_raw, pcd_eff;
  logic [CW-1:0] ratio;
  logic          bound;

  assign pcd_raw = {div_hi_i, div_lo_i};
  assign ratio   = CW'(pcd_eff) + CW'(2);

  pcd_limit #(.PW(PW), .MW(MD_W)) u_limit (
    .pcd_i   (pcd_raw),
    .mode_i  (panel_mode_i),
    .stn_i   (stn_en_i),
    .pcd_o   (pcd_eff),
    .clamp_o (div_clamp_o)
  );

  pclk_divider #(.CW(CW)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ratio_i   (ratio),
    .pclk_o    (pclk_o),
    .pclk_en_o (pclk_en_o),
    .bound_o   (bound)
  );

  bias_toggle #(.LW(BIAS_W)) u_bias (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stn_i  (stn_en_i),
    .line_i (line_done_i),
    .load_i (bound),
    .len_i  (bias_len_i),
    .bias_o (bias_o)
  );

  AST_DUAL_MONO8_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound && stn_en_i && (panel_mode_i == MD_W'(5)) |=> u_div.term_q >= CW'(15)); // R2
  AST_TFT_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stn_en_i |-> !div_clamp_o); // R4

endmodule

// File: tb/lcd_pclk_bias_test.sv
`timescale 1ns/1ps
module lcd_pclk_bias_test;

  typedef struct {
    int    ratio;
    int    high;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_done = 1'b0;
  logic [4:0] div_lo = '0, div_hi = '0, bias_len = '0;
  logic [2:0] mode = '0;
  logic       stn = 1'b1;
  logic       pclk, pclk_en, bias, clamp;

  int checks = 0, fails = 0;
  exp_t q[$];
  int mon_cyc = 0, mon_hi = 0;

  always #2.5 clk = ~clk;

  lcd_pclk_bias uut (
    .clk_i(clk), .rst_ni(rst_n), .line_done_i(line_done),
    .div_lo_i(div_lo), .div_hi_i(div_hi), .bias_len_i(bias_len),
    .panel_mode_i(mode), .stn_en_i(stn),
    .pclk_o(pclk), .pclk_en_o(pclk_en), .bias_o(bias), .div_clamp_o(clamp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: measure each period between enable pulses, compare with scoreboard.
  always @(negedge clk) begin
    if (rst_n && pclk_en) begin
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(mon_cyc == e.ratio && mon_hi == e.high, e.req,
              mon_cyc * 1000 + mon_hi, e.ratio * 1000 + e.high);
      end
      mon_cyc = 1;
      mon_hi  = 1;
    end else begin
      mon_cyc++;
      mon_hi += int'(pclk);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  task automatic wait_en();
    do @(negedge clk); while (!pclk_en);
  endtask

  task automatic set_div(input int pcd, input int md, input bit s);
    @(negedge clk);
    div_lo = 5'(pcd);
    div_hi = 5'(pcd >> 5);
    mode   = 3'(md);
    stn    = s;
  endtask

  // Driver: load settings, wait for first new period, push expected periods.
  task automatic run_case(input int pcd, input int md, input bit s, input int ratio,
                          input bit flag, input string req);
    set_div(pcd, md, s);
    #1 check(clamp == flag, {req, " R3 flag"}, int'(clamp), int'(flag));
    wait_en();
    @(posedge clk);
    for (int i = 0; i < 3; i++) q.push_back('{ratio, ratio / 2, req});
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic pulse_line();
    @(negedge clk) line_done = 1'b1;
    @(negedge clk) line_done = 1'b0;
  endtask

  initial begin
    int n;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(pclk == 1'b0, "R10 pclk", int'(pclk), 0);
    check(pclk_en == 1'b0, "R10 en", int'(pclk_en), 0);
    check(bias == 1'b0, "R10 bias", int'(bias), 0);
    rst_n = 1'b1;

    // R7 bias period of 3 lines, divide-by-3 clock
    set_div(1, 0, 1'b1);
    bias_len = 5'd2;
    repeat (10) @(negedge clk);
    pulse_line(); pulse_line();
    check(bias == 1'b0, "R7 before third line", int'(bias), 0);
    pulse_line();
    check(bias == 1'b1, "R7 third line", int'(bias), 1);
    pulse_line(); pulse_line(); pulse_line();
    check(bias == 1'b0, "R7 sixth line", int'(bias), 0);

    bias_len = 5'd0;
    repeat (10) @(negedge clk);
    pulse_line();
    check(bias == 1'b1, "R7 one-line period", int'(bias), 1);

    // R8 TFT mode: bias low, strobes ignored, state cleared
    @(negedge clk) stn = 1'b0;
    #1 check(bias == 1'b0, "R8 tft low", int'(bias), 0);
    pulse_line(); pulse_line(); pulse_line();
    check(bias == 1'b0, "R8 strobes ignored", int'(bias), 0);
    @(negedge clk) stn = 1'b1;
    repeat (10) @(negedge clk);
    check(bias == 1'b0, "R8 resume low", int'(bias), 0);
    pulse_line();
    check(bias == 1'b1, "R8 fresh count", int'(bias), 1);

    // R9 strobe and bias-period load on the same edge
    wait_en();
    @(negedge clk);
    @(negedge clk);
    bias_len  = 5'd3;
    line_done = 1'b1;
    @(negedge clk);
    line_done = 1'b0;
    check(bias == 1'b0, "R9 old period used", int'(bias), 0);
    repeat (4) @(negedge clk);
    pulse_line(); pulse_line(); pulse_line();
    check(bias == 1'b0, "R9 new period not yet", int'(bias), 0);
    pulse_line();
    check(bias == 1'b1, "R9 new period four lines", int'(bias), 1);

    // Divider scoreboard
    run_case(0,   0, 1'b1, 3,  1'b1, "R2 single colour clamp");
    run_case(1,   0, 1'b1, 3,  1'b0, "R1 R5 odd ratio 3");
    run_case(3,   5, 1'b1, 16, 1'b1, "R2 dual mono8 clamp");
    run_case(20,  5, 1'b1, 22, 1'b0, "R1 R5 ratio 22");
    run_case(0,   2, 1'b1, 4,  1'b1, "R2 single mono4 clamp");
    run_case(5,   4, 1'b1, 8,  1'b1, "R2 single mono8 clamp");
    run_case(3,   1, 1'b1, 6,  1'b1, "R2 dual colour clamp");
    run_case(0,   3, 1'b0, 2,  1'b0, "R4 tft ratio 2");
    run_case(34,  0, 1'b1, 36, 1'b0, "R1 upper field");
    run_case(9,   5, 1'b0, 11, 1'b0, "R4 R5 tft odd 11");

    // R6 mid-period change does not cut the running period
    run_case(20, 0, 1'b1, 22, 1'b0, "R1 ratio 22 again");
    wait_en();
    n = 1;
    @(negedge clk);
    div_lo = 5'd1;
    div_hi = 5'd0;
    do begin @(negedge clk); n++; end while (!pclk_en);
    check(n == 22, "R6 running period kept", n, 22);
    n = 0;
    do begin @(negedge clk); n++; end while (!pclk_en);
    check(n == 3, "R6 new ratio next period", n, 3);

    finish_run();
  end

endmodule